// File: doc/BRIEF.md
# SPI Register-Port Slave

This block lets an external host read and write a 64-entry register file over a four-wire SPI link. The link runs in mode 0: MOSI is sampled on the rising SCK edge, MISO changes on the falling edge, and bytes travel most significant bit first. The block is always a slave. It never drives SCK. The SPI pins are synchronised into the system clock domain. Every transfer is framed by chip select held low.

The first byte of a transfer is an address byte:
- bit 7 is the mode (0 = write, 1 = read);
- bits 6:1 are the register address;
- bit 0 must be 0.

After a write address byte, every further byte is written to that same address. A host can therefore stream data into a single data-port register. In a read, every MOSI byte is another address. During the byte that follows, MISO returns the contents of the address just sent. A host usually ends a read with a 00h byte.

The register file sits outside the block. The block drives a one-cycle write strobe with address and data. It also drives a one-cycle read strobe with an address, and captures the read data presented in that same cycle.

Top module: `spi_regport`

## Requirements
- R1: After reset, `reg_wr_en`, `reg_rd_en` and `spi_miso` are all 0.
- R2: A byte is assembled from eight rising SCK edges while `spi_cs_n` is low, MSB first. In the first byte, bit 7 = 0 selects write and bits 6:1 give the address.
- R3: After a write address byte with bit 0 = 0, each following complete byte gives exactly one `reg_wr_en` pulse. The pulse carries the address from the address byte and the received byte as data.
- R4: A write address byte with bit 0 = 1 produces no `reg_wr_en` pulse for the rest of that transfer, and the register file keeps its contents.
- R5: A first byte with bit 7 = 1 selects read. Each complete MOSI byte then gives one `reg_rd_en` pulse with `reg_rd_addr` = bits 6:1 of that byte. During the next byte, MISO shifts out the `reg_rd_data` captured at that pulse, MSB first. During the first byte of a read, MISO is 0.
- R6: Raising `spi_cs_n` in the middle of a byte discards the partial bits and issues no strobe for them.
- R7: Raising `spi_cs_n` ends the transfer, so the next byte after chip select goes low again is decoded as a fresh address byte. The mode may change from one transfer to the next.
- R8: Each strobe is a single system-clock pulse. It goes high in the 4th system clock after the SCK rising edge that completes its byte: two synchroniser stages, one byte-assembly register and one strobe register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 6 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_addr | output | 6 | Register read address |
| reg_rd_data | input | 8 | Register read data, valid in the cycle `reg_rd_en` is high |

## Verification
Each write or read strobe is due exactly four system clocks after the SCK rising edge that ends its byte. The bench time-stamps every rising edge it drives and compares that stamp with the cycle in which the strobe is seen, checking at the falling clock edge.

MISO bits are sampled just before the bench drives the next SCK rising edge, half an SCK period after the falling edge that moved them. That edge is at least eight system clocks after the strobe that loaded the byte.

Strobes are matched every clock against queues of expected writes and reads built from the sent bytes. Each queue must be empty once chip select has risen, so both a missing strobe and an extra strobe are reported.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_ADDR  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } xfer_state_t;

  // register address field of an address byte: bits 6:1
  function automatic logic [ADDR_W-1:0] addr_field(input logic [BYTE_W-1:0] b);
    return b[ADDR_W:1];
  endfunction

  // mode bit: 1 selects read
  function automatic logic mode_is_read(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  // a write address byte is honoured only when its low bit is clear
  function automatic logic write_legal(input logic [BYTE_W-1:0] b);
    return ~b[0];
  endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_regport_shift.sv
module spi_regport_shift
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              sck_rise,
  output logic              sck_fall,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              miso
);

  logic              sck_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign miso     = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      sck_d    <= sck_s;
      byte_vld <= 1'b0;
      if (!cs_act) begin
        // chip select high: drop any partial byte and idle MISO low
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + CNT_W'(1);
          if (bit_cnt == CNT_W'(BYTE_W-1)) begin
            byte_vld <= 1'b1;
            byte_q   <= {rx_sh, mosi_s};
          end
        end
        // the falling edge at a byte boundary must not consume the new MSB
        if (load)
          tx_sh <= load_data;
        else if (sck_fall && bit_cnt != '0)
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_armed
);

  xfer_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ADDR;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      wr_armed <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (byte_vld) begin
        unique case (state)
          ST_ADDR: begin
            if (mode_is_read(byte_q)) begin
              rd_en   <= 1'b1;
              rd_addr <= addr_field(byte_q);
              state   <= ST_READ;
            end else begin
              wr_addr  <= addr_field(byte_q);
              wr_armed <= write_legal(byte_q);
              state    <= ST_WRITE;
            end
          end
          ST_WRITE: begin
            if (wr_armed) begin
              wr_en   <= 1'b1;
              wr_data <= byte_q;
            end
          end
          ST_READ: begin
            rd_en   <= 1'b1;
            rd_addr <= addr_field(byte_q);
          end
          default: state <= ST_ADDR;
        endcase
      end else if (!cs_act) begin
        state    <= ST_ADDR;
        wr_armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [BYTE_W-1:0] reg_rd_data
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0]  pins_s;
  logic              sck_s, cs_n_s, mosi_s, cs_act;
  logic              sck_rise, sck_fall, byte_vld, wr_armed;
  logic [BYTE_W-1:0] byte_q;

  spi_regport_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({spi_cs_n, spi_mosi, spi_sck}),
    .dout  (pins_s)
  );

  assign {cs_n_s, mosi_s, sck_s} = pins_s;
  assign cs_act = ~cs_n_s;

  spi_regport_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s),
    .load      (reg_rd_en),
    .load_data (reg_rd_data),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .byte_vld  (byte_vld),
    .byte_q    (byte_q),
    .miso      (spi_miso)
  );

  spi_regport_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .rd_en    (reg_rd_en),
    .rd_addr  (reg_rd_addr),
    .wr_armed (wr_armed)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
  import spi_regport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sck_rise,
  input logic              byte_vld,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [BYTE_W-1:0] rd_data,
  input logic              miso
);

  // R2: an assembled byte always follows a detected SCK rising edge
  a_r2_byte_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(sck_rise));

  // R6: no byte completes once chip select was high the cycle before
  a_r6_no_byte_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_act) |-> !byte_vld);

  // R3: burst writes keep the address taken from the address byte
  a_r3_burst_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $stable(wr_addr));

  // R8: strobes last one cycle
  a_r8_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r8_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R5: read data MSB reaches MISO the cycle after the read strobe
  a_r5_miso_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cs_act) |=> (miso == $past(rd_data[BYTE_W-1])));

endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .sck_rise (sck_rise),
  .byte_vld (byte_vld),
  .wr_en    (reg_wr_en),
  .wr_addr  (reg_wr_addr),
  .rd_en    (reg_rd_en),
  .rd_data  (reg_rd_data),
  .miso     (spi_miso)
);

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;

  localparam int HALF    = 8;
  localparam int LATENCY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic       wr_en, rd_en;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  always #2 clk = ~clk;

  spi_regport uut (
    .clk (clk), .rst_n (rst_n),
    .spi_sck (spi_sck), .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi), .spi_miso (spi_miso),
    .reg_wr_en (wr_en), .reg_wr_addr (wr_addr), .reg_wr_data (wr_data),
    .reg_rd_en (rd_en), .reg_rd_addr (rd_addr), .reg_rd_data (rd_data)
  );

  // register file beside the block, plus the bench's own expected copy
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  assign rd_data = mem[rd_addr];
  always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rise_cyc = 0;
  string tag = "R1";
  logic [7:0]  bq[$];
  logic [7:0]  exp_miso[$];
  logic [13:0] exp_wr[$];
  logic [5:0]  exp_rd[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected end before it", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // per-clock strobe comparison against the expected queues
  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      n_chk++;
      if (exp_wr.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected write actual %h/%h expected none", tag, wr_addr, wr_data);
      end else begin
        logic [13:0] e;
        e = exp_wr.pop_front();
        if ({wr_addr, wr_data} != e) begin
          n_fail++;
          $display("FAIL %s: write actual %h/%h expected %h/%h", tag, wr_addr, wr_data, e[13:8], e[7:0]);
        end
      end
      n_chk++;
      if (cyc - rise_cyc != LATENCY) begin
        n_fail++;
        $display("FAIL R8: write latency actual %0d expected %0d", cyc - rise_cyc, LATENCY);
      end
    end
    if (rd_en) begin
      n_chk++;
      if (exp_rd.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected read actual %h expected none", tag, rd_addr);
      end else begin
        logic [5:0] e;
        e = exp_rd.pop_front();
        if (rd_addr != e) begin
          n_fail++;
          $display("FAIL %s: read addr actual %h expected %h", tag, rd_addr, e);
        end
      end
      n_chk++;
      if (cyc - rise_cyc != LATENCY) begin
        n_fail++;
        $display("FAIL R8: read latency actual %0d expected %0d", cyc - rise_cyc, LATENCY);
      end
    end
  end

  // expected behaviour of one transfer, from the requirements alone
  task automatic plan();
    exp_miso.delete();
    if (bq.size() == 0) return;
    if (bq[0][7] == 1'b0) begin
      for (int i = 0; i < bq.size(); i++) exp_miso.push_back(8'h00);
      if (bq[0][0] == 1'b0)
        for (int i = 1; i < bq.size(); i++) begin
          exp_wr.push_back({bq[0][6:1], bq[i]});
          exp_mem[bq[0][6:1]] = bq[i];
        end
    end else begin
      exp_miso.push_back(8'h00);
      for (int i = 0; i < bq.size(); i++) begin
        exp_rd.push_back(bq[i][6:1]);
        if (i > 0) exp_miso.push_back(exp_mem[bq[i-1][6:1]]);
      end
    end
  endtask

  task automatic clock_bit(input logic b, output logic got);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    got = spi_miso;
    spi_sck = 1'b1;
    rise_cyc = cyc;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic xfer(input int part_bits);
    logic [7:0] rx;
    logic g;
    plan();
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < bq.size(); i++) begin
      for (int b = 7; b >= 0; b--) begin
        clock_bit(bq[i][b], g);
        rx[b] = g;
      end
      n_chk++;
      if (rx != exp_miso[i]) begin
        n_fail++;
        $display("FAIL %s: MISO byte %0d actual %h expected %h", tag, i, rx, exp_miso[i]);
      end
    end
    for (int b = 0; b < part_bits; b++) clock_bit(1'b1, g);
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    n_chk++;
    if (exp_wr.size() != 0 || exp_rd.size() != 0) begin
      n_fail++;
      $display("FAIL %s: missing strobes actual %0d/%0d pending expected 0/0", tag, exp_wr.size(), exp_rd.size());
      exp_wr.delete();
      exp_rd.delete();
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (wr_en !== 1'b0 || rd_en !== 1'b0 || spi_miso !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual wr=%b rd=%b miso=%b expected 0/0/0", wr_en, rd_en, spi_miso);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R3: burst of three writes to address 5 (address byte 0Ah)
    tag = "R3";
    bq = '{8'h0A, 8'h11, 8'h22, 8'h33};
    xfer(0);

    // R5: read address 5 then 2, closing with 00h
    tag = "R5";
    bq = '{8'h8A, 8'h84, 8'h00};
    xfer(0);

    // R4: write address byte with bit 0 set, then read address 5 back
    tag = "R4";
    bq = '{8'h0B, 8'h99, 8'h5A};
    xfer(0);
    bq = '{8'h8A, 8'h00};
    xfer(0);

    // R6: one full data byte to address 8, then a 5-bit fragment aborted
    tag = "R6";
    bq = '{8'h10, 8'hA5};
    xfer(5);
    bq = '{8'h90, 8'h00};
    xfer(0);

    // R7: transfers of alternating mode at the top address and address 0
    tag = "R7";
    bq = '{8'h7E, 8'hC3, 8'h3C};
    xfer(0);
    bq = '{8'hFE, 8'h80, 8'h00};
    xfer(0);
    tag = "R2";
    bq = '{8'h02, 8'h96};
    xfer(0);
    bq = '{8'h82, 8'hFE, 8'h00};
    xfer(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule